// File: doc/BRIEF.md
# Compressed-ISA Branch Target Unit

This block resolves control transfers for a 16-bit compressed instruction set. Each cycle it may accept one instruction word with its address, the four condition flags, a general register operand and the current link-register value. One cycle later it reports whether the program counter must be redirected and, if so, the halfword-aligned target. It also reports whether the link register must be written and with what value, whether the core must leave compressed state, and whether the word is a software trap or an undefined branch encoding.

All offsets are taken relative to the instruction address plus 4. The long call is split across two consecutive instruction words. The first half parks a partial target in the link register. The second half adds its own low offset to that value, jumps, and leaves the return address in the link register. When pair tracking is enabled, the unit remembers whether the previous accepted word was a first half and refuses a second half that arrives alone. Fetch, the register file and exception entry sit outside this block and act on its outputs.

Top module: `cbr_unit`

## Requirements
- R1: After reset, and in the cycle after any cycle with `in_valid` low, every output is 0. For an accepted word, the results appear on the outputs exactly one clock later with `out_valid` high.
- R2: A word with bits 15:12 = 1101 and a condition field (bits 11:8) below 1110 whose condition holds redirects to address + 4 + (sign-extended bits 7:0 shifted left by 1).
- R3: The condition field is evaluated against `flags_nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R4: A conditional branch whose condition fails produces `out_valid` with every other output 0.
- R5: A word with bits 15:11 = 11100 redirects to address + 4 + (sign-extended bits 10:0 shifted left by 1); 0xE7FE targets its own address.
- R6: A word with bits 15:11 = 11110 writes the link register with address + 4 + (sign-extended bits 10:0 shifted left by 12) and does not redirect.
- R7: A word with bits 15:11 = 11111 that directly follows a first half redirects to `lr_in` + (bits 10:0 zero-extended, shifted left by 1) with bit 0 cleared, and writes the link register with (address + 2) with bit 0 set.
- R8: With `TRACK_PAIR` = 1, a second half whose previous accepted word was not a first half raises `undef_hit` and neither redirects nor writes the link register.
- R9: A word with bits 15:7 = 010001110 redirects to `reg_val` with bit 0 cleared. `to_wide` is high exactly when bit 0 of `reg_val` is 0.
- R10: A word with bits 15:7 = 010001111 raises `undef_hit` and does not redirect.
- R11: A word with bits 15:8 = 0xDF raises `swi_hit` and redirects to `SWI_VEC` (default 0x8), whatever its low 8 bits hold.
- R12: A word with bits 15:8 = 0xDE raises `undef_hit` and neither redirects nor writes the link register.
- R13: Any other word produces `out_valid` with every other output 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word presented this cycle |
| insn | input | 16 | Instruction word |
| insn_addr | input | AW (32) | Address of the instruction word |
| flags_nzcv | input | 4 | Condition flags, N in bit 3 down to V in bit 0 |
| reg_val | input | AW (32) | Register operand for branch-and-exchange |
| lr_in | input | AW (32) | Current link-register value |
| out_valid | output | 1 | Result of the word accepted one cycle earlier |
| redirect | output | 1 | Program counter must be redirected |
| target | output | AW (32) | Redirect address, bit 0 always 0 |
| lr_we | output | 1 | Link register must be written |
| lr_data | output | AW (32) | Value for the link register |
| to_wide | output | 1 | Exchange selects the 32-bit state |
| swi_hit | output | 1 | Software trap encoding seen |
| undef_hit | output | 1 | Undefined branch encoding seen |

## Verification
A wrong condition mapping shows as a missing or spurious `redirect` in the result cycle that follows the conditional word. An error in offset scaling or sign extension shows as a wrong `target` or `lr_data` in that same cycle. A stale or wrongly cleared pair tracker cannot be seen on the first word. It shows one word later, when a second half is redirected although it should have been refused, or refused although it should have been redirected. Mixing random flags and words with back-to-back halves, lone halves and halves separated by other words brings each of these errors out within a few cycles.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [3:0] {
    K_OTHER,
    K_BCOND,
    K_BCOND_UND,
    K_SWI,
    K_BUNC,
    K_CALL_HI,
    K_CALL_LO,
    K_XCHG,
    K_XCHG_UND
  } br_kind_e;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [8:0] hdr,   // instruction bits 15:7
  output br_kind_e   kind
);
  logic [3:0] top4;
  logic [4:0] top5;
  logic [3:0] cnd;

  assign top4 = hdr[8:5];
  assign top5 = hdr[8:4];
  assign cnd  = hdr[4:1];

  always_comb begin
    kind = K_OTHER;
    if (top4 == 4'b1101) begin
      if (cnd == 4'hF)      kind = K_SWI;
      else if (cnd == 4'hE) kind = K_BCOND_UND;
      else                  kind = K_BCOND;
    end else if (top5 == 5'b11100) begin
      kind = K_BUNC;
    end else if (top5 == 5'b11110) begin
      kind = K_CALL_HI;
    end else if (top5 == 5'b11111) begin
      kind = K_CALL_LO;
    end else if (hdr[8:1] == 8'h47) begin
      kind = hdr[0] ? K_XCHG_UND : K_XCHG;
    end
  end
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval #(
  parameter int NBASE = 8
) (
  input  logic [3:0] cond,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v;
  logic [NBASE-1:0] base;

  assign n = nzcv[3];
  assign z = nzcv[2];
  assign c = nzcv[1];
  assign v = nzcv[0];

  // Each even code tests a base predicate, the odd code after it tests its inverse.
  assign base[0] = z;
  assign base[1] = c;
  assign base[2] = n;
  assign base[3] = v;
  assign base[4] = c & ~z;
  assign base[5] = (n == v);
  assign base[6] = ~z & (n == v);
  assign base[7] = 1'b0;

  assign pass = base[cond[3:1]] ^ cond[0];
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int          AW      = 32,
  parameter logic [31:0] SWI_VEC = 32'h8
) (
  input  br_kind_e      kind,
  input  logic [10:0]   imm,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] lr_in,
  output logic [AW-1:0] tgt,
  output logic [AW-1:0] lr_val,
  output logic          wide
);
  localparam int PC_AHEAD = 4;
  localparam int NEXT_STEP = 2;

  logic [AW-1:0] pc_rd, next_addr, off_short, off_long, off_hi, off_lo, raw;

  assign pc_rd     = addr + AW'(PC_AHEAD);
  assign next_addr = addr + AW'(NEXT_STEP);
  assign off_short = {{(AW-9){imm[7]}}, imm[7:0], 1'b0};
  assign off_long  = {{(AW-12){imm[10]}}, imm, 1'b0};
  assign off_hi    = {{(AW-23){imm[10]}}, imm, 12'b0};
  assign off_lo    = {{(AW-12){1'b0}}, imm, 1'b0};

  always_comb begin
    case (kind)
      K_BCOND:   raw = pc_rd + off_short;
      K_BUNC:    raw = pc_rd + off_long;
      K_CALL_LO: raw = lr_in + off_lo;
      K_XCHG:    raw = reg_val;
      K_SWI:     raw = SWI_VEC[AW-1:0];
      default:   raw = '0;
    endcase
  end

  assign tgt = {raw[AW-1:1], 1'b0};

  always_comb begin
    case (kind)
      K_CALL_HI: lr_val = pc_rd + off_hi;
      K_CALL_LO: lr_val = {next_addr[AW-1:1], 1'b1};
      default:   lr_val = '0;
    endcase
  end

  assign wide = (kind == K_XCHG) && !reg_val[0];
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [31:0] SWI_VEC    = 32'h8,
  parameter bit          TRACK_PAIR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] insn_addr,
  input  logic [3:0]    flags_nzcv,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] lr_in,
  output logic          out_valid,
  output logic          redirect,
  output logic [AW-1:0] target,
  output logic          lr_we,
  output logic [AW-1:0] lr_data,
  output logic          to_wide,
  output logic          swi_hit,
  output logic          undef_hit
);
  br_kind_e      kind;
  logic          cond_ok, pair_ok;
  logic [AW-1:0] tgt_c, lrv_c;
  logic          wide_c;
  logic          nx_redir, nx_lrwe, nx_swi, nx_undef, nx_wide;

  cbr_decode u_dec (
    .hdr  (insn[15:7]),
    .kind (kind)
  );

  cbr_cond_eval #(.NBASE(8)) u_cond (
    .cond (insn[11:8]),
    .nzcv (flags_nzcv),
    .pass (cond_ok)
  );

  cbr_target #(.AW(AW), .SWI_VEC(SWI_VEC)) u_tgt (
    .kind    (kind),
    .imm     (insn[10:0]),
    .addr    (insn_addr),
    .reg_val (reg_val),
    .lr_in   (lr_in),
    .tgt     (tgt_c),
    .lr_val  (lrv_c),
    .wide    (wide_c)
  );

  generate
    if (TRACK_PAIR) begin : g_pair
      logic prev_hi;
      always_ff @(posedge clk) begin
        if (rst)           prev_hi <= 1'b0;
        else if (in_valid) prev_hi <= (kind == K_CALL_HI);
      end
      assign pair_ok = prev_hi;

      // R8: a lone second half is refused
      assert_lone_second_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[15:11] == 5'b11111 && !prev_hi) |=> (undef_hit && !redirect && !lr_we));
    end else begin : g_nopair
      assign pair_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    nx_redir = 1'b0;
    nx_lrwe  = 1'b0;
    nx_swi   = 1'b0;
    nx_undef = 1'b0;
    nx_wide  = 1'b0;
    case (kind)
      K_BCOND:     nx_redir = cond_ok;
      K_BUNC:      nx_redir = 1'b1;
      K_CALL_HI:   nx_lrwe  = 1'b1;
      K_CALL_LO: begin
        nx_redir = pair_ok;
        nx_lrwe  = pair_ok;
        nx_undef = !pair_ok;
      end
      K_XCHG: begin
        nx_redir = 1'b1;
        nx_wide  = wide_c;
      end
      K_SWI: begin
        nx_redir = 1'b1;
        nx_swi   = 1'b1;
      end
      K_XCHG_UND:  nx_undef = 1'b1;
      K_BCOND_UND: nx_undef = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      redirect  <= 1'b0;
      target    <= '0;
      lr_we     <= 1'b0;
      lr_data   <= '0;
      to_wide   <= 1'b0;
      swi_hit   <= 1'b0;
      undef_hit <= 1'b0;
    end else begin
      out_valid <= in_valid;
      redirect  <= in_valid && nx_redir;
      target    <= (in_valid && nx_redir) ? tgt_c : '0;
      lr_we     <= in_valid && nx_lrwe;
      lr_data   <= (in_valid && nx_lrwe) ? lrv_c : '0;
      to_wide   <= in_valid && nx_wide;
      swi_hit   <= in_valid && nx_swi;
      undef_hit <= in_valid && nx_undef;
    end
  end

  // R1: an idle cycle leaves all outputs low in the next cycle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !redirect && !lr_we && !swi_hit && !undef_hit && !to_wide));

  // R2: redirect addresses are halfword aligned
  assert_even_target_R2: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !target[0]);

  // R9: the exchange to the wide state follows a register value with bit 0 clear
  assert_wide_exchange_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[15:7] == 9'b010001110 && !reg_val[0]) |=> (to_wide && redirect));

  // R10: the exchange form with bit 7 set is refused
  assert_xchg_undef_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[15:7] == 9'b010001111) |=> (undef_hit && !redirect));

  // R11: the trap word always reaches the fixed vector
  assert_swi_vector_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[15:8] == 8'hDF) |=> (swi_hit && redirect && target == SWI_VEC[AW-1:0]));

  // R12: undefined results carry no side effects
  assert_undef_silent_R12: assert property (@(posedge clk) disable iff (rst)
    undef_hit |-> (!redirect && !lr_we && !swi_hit));
endmodule

// File: tb/cbr_unit_test.sv
module cbr_unit_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [15:0]   insn = '0;
  logic [AW-1:0] insn_addr = '0;
  logic [3:0]    flags_nzcv = '0;
  logic [AW-1:0] reg_val = '0;
  logic [AW-1:0] lr_in = '0;
  logic          out_valid, redirect, lr_we, to_wide, swi_hit, undef_hit;
  logic [AW-1:0] target, lr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit prev_hi = 1'b0;

  logic          e_valid, e_redir, e_lrwe, e_wide, e_swi, e_undef;
  logic [AW-1:0] e_tgt, e_lrd;
  string         e_req;

  always #10 clk = ~clk;

  cbr_unit #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .insn_addr(insn_addr),
    .flags_nzcv(flags_nzcv), .reg_val(reg_val), .lr_in(lr_in),
    .out_valid(out_valid), .redirect(redirect), .target(target), .lr_we(lr_we),
    .lr_data(lr_data), .to_wide(to_wide), .swi_hit(swi_hit), .undef_hit(undef_hit)
  );

  function automatic bit cond_holds(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [15:0] w, input logic [AW-1:0] a,
                       input logic [3:0] f, input logic [AW-1:0] rv, input logic [AW-1:0] lr);
    int signed s8, s11;
    e_valid = v; e_redir = 0; e_lrwe = 0; e_wide = 0; e_swi = 0; e_undef = 0;
    e_tgt = 0; e_lrd = 0; e_req = "R1";
    if (v) begin
      s8  = $signed(w[7:0]);
      s11 = $signed(w[10:0]);
      e_req = "R13";
      if (w[15:8] == 8'hDF) begin
        e_req = "R11"; e_redir = 1; e_swi = 1; e_tgt = 32'h8;
      end else if (w[15:8] == 8'hDE) begin
        e_req = "R12"; e_undef = 1;
      end else if (w[15:12] == 4'b1101) begin
        if (cond_holds(w[11:8], f)) begin
          e_req = "R2 R3"; e_redir = 1; e_tgt = a + 4 + (s8 * 2);
        end else e_req = "R4 R3";
      end else if (w[15:11] == 5'b11100) begin
        e_req = "R5"; e_redir = 1; e_tgt = a + 4 + (s11 * 2);
      end else if (w[15:11] == 5'b11110) begin
        e_req = "R6"; e_lrwe = 1; e_lrd = a + 4 + (s11 * 4096);
      end else if (w[15:11] == 5'b11111) begin
        if (prev_hi) begin
          e_req = "R7"; e_redir = 1; e_lrwe = 1;
          e_tgt = (lr + {w[10:0], 1'b0}) & ~32'd1;
          e_lrd = (a + 2) | 32'd1;
        end else begin
          e_req = "R8"; e_undef = 1;
        end
      end else if (w[15:7] == 9'b010001110) begin
        e_req = "R9"; e_redir = 1; e_tgt = rv & ~32'd1; e_wide = !rv[0];
      end else if (w[15:7] == 9'b010001111) begin
        e_req = "R10"; e_undef = 1;
      end
      prev_hi = (w[15:11] == 5'b11110);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic [AW-1:0] a,
                      input logic [3:0] f, input logic [AW-1:0] rv, input logic [AW-1:0] lr);
    in_valid = v; insn = w; insn_addr = a; flags_nzcv = f; reg_val = rv; lr_in = lr;
    model(v, w, a, f, rv, lr);
    @(negedge clk);
    check(e_req, "out_valid", AW'(out_valid), AW'(e_valid));
    check(e_req, "redirect",  AW'(redirect),  AW'(e_redir));
    check(e_req, "target",    target,         e_tgt);
    check(e_req, "lr_we",     AW'(lr_we),     AW'(e_lrwe));
    check(e_req, "lr_data",   lr_data,        e_lrd);
    check(e_req, "to_wide",   AW'(to_wide),   AW'(e_wide));
    check(e_req, "swi_hit",   AW'(swi_hit),   AW'(e_swi));
    check(e_req, "undef_hit", AW'(undef_hit), AW'(e_undef));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] w;
    logic [AW-1:0] a;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid after reset", AW'(out_valid), 0);
    check("R1", "redirect after reset",  AW'(redirect), 0);
    rst = 1'b0;

    // R5: branch to self
    step(1, 16'hE7FE, 32'h100, 4'h0, 0, 0);
    // R2 R3: equal taken, then not taken (R4)
    step(1, 16'hD005, 32'h200, 4'b0100, 0, 0);
    step(1, 16'hD005, 32'h200, 4'b0000, 0, 0);
    // backward conditional, signed-greater
    step(1, 16'hDC80, 32'h400, 4'b0000, 0, 0);
    // R12: condition 1110
    step(1, 16'hDE12, 32'h300, 4'hF, 0, 0);
    // R11: trap with two different low bytes
    step(1, 16'hDF00, 32'h500, 4'h0, 0, 0);
    step(1, 16'hDFA5, 32'h502, 4'hF, 0, 0);
    // R6 then R7: back-to-back call halves
    step(1, 16'hF7FF, 32'h1000, 4'h0, 0, 0);
    step(1, 16'hF802, 32'h1002, 4'h0, 0, lr_data);
    // R8: lone second half, then a half separated by another word
    step(1, 16'hF810, 32'h2000, 4'h0, 0, 32'h4000);
    step(1, 16'hF001, 32'h2100, 4'h0, 0, 0);
    step(1, 16'h1C08, 32'h2102, 4'h0, 0, 0);
    step(1, 16'hF810, 32'h2104, 4'h0, 0, 32'h4000);
    // R9: exchange to both states; R10: refused form
    step(1, 16'h4708, 32'h600, 4'h0, 32'h8000_1234, 0);
    step(1, 16'h4708, 32'h600, 4'h0, 32'h8000_1235, 0);
    step(1, 16'h47F0, 32'h600, 4'h0, 32'h8000_1235, 0);
    // R13: ordinary word; R1: idle cycle
    step(1, 16'h1C08, 32'h700, 4'hF, 0, 0);
    step(0, 16'hE7FE, 32'h700, 4'hF, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      w = 16'($urandom);
      a = {$urandom} & ~32'd1;
      case ($urandom % 8)
        0: w[15:12] = 4'b1101;
        1: w[15:11] = 5'b11100;
        2: w[15:11] = 5'b11110;
        3: w[15:11] = 5'b11111;
        4: begin w[15:8] = 8'h47; w[7] = ($urandom % 4 == 0); end
        5: w[15:8] = 8'hDF;
        6: ;
        default: begin
          step(1, {5'b11110, 11'($urandom)}, a, 4'($urandom), $urandom, $urandom);
          w[15:11] = 5'b11111;
          a = a + 2;
        end
      endcase
      step(($urandom % 10) != 0, w, a, 4'($urandom), $urandom, lr_data);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule